// File: doc/BRIEF.md
# Capacitor Balancing Duty Adjuster

This block keeps four series-stacked DC-link capacitors at equal voltage by nudging the four duty ratios that a carrier-overlapped modulator produces for one phase leg. Each of the three neighbouring capacitor pairs (1/2, 2/3, 3/4) has its own discrete PI controller. The controller's input is the voltage step across that pair. Its output is an adjustment that is added to one duty of the matching neighbouring duty pair and taken from the other. The sign of the phase output current sets which way the adjustment goes. Because every raise has a matching cut, the summed duty, and with it the average pole voltage, is left as the modulator asked.

Every update takes place on a single sample strobe. On that strobe the block reads the capacitor voltages, the signed output current, the base duties, the gains and the adjustment limit. It advances each integrator and registers four corrected duties. Those duties are saturated to the range 0..1 and announced by a one-cycle valid pulse. Between strobes the outputs and the integrator state hold.

Duties are unsigned fixed point with `FRAC` fractional bits, so 1.0 is `2**FRAC` (16384 by default). Gains act through a product followed by an arithmetic right shift of `SH` bits, which rounds toward minus infinity.

Top module: `cap_balance_adj`

## Requirements
- R1: While reset is asserted and after it is released, before the first strobe, `duty_out` is all zero, `out_valid` is low and all three integrators are zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `sample_stb` is high. Without a strobe, `duty_out` keeps its value.
- R3: For pair k (capacitor k against k+1, k = 0..2), the error is e = v[k+1] − v[k]. With a non-negative current, a positive adjustment a is added to duty k+1 and subtracted from duty k.
- R4: An output current of exactly zero is treated as positive (sign +1).
- R5: A negative output current (two's complement, MSB set) reverses the direction of every pair's adjustment.
- R6: Each pair changes its two duties by equal and opposite amounts, so without saturation the sum of the four corrected duties equals the sum of the four base duties.
- R7: The proportional term is floor(kp·e / 2^SH).
- R8: On each strobe the integrator becomes clamp(I + floor(ki·e / 2^SH), ±adj_max). The adjustment uses this updated value.
- R9: Each pair's adjustment, clamp(P + I, ±adj_max), never exceeds `adj_max` in magnitude.
- R10: Each corrected duty is saturated to the range 0..2^FRAC.
- R11: The corrected duty k is base k plus the adjustment of pair k−1 minus the adjustment of pair k, sign applied. The two middle duties therefore receive contributions from two pairs.
- R12: Input changes without a strobe leave the integrators untouched. The next strobe advances them exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle sample strobe |
| vcap | input | NCAP*VW | Capacitor voltages, capacitor k in bits [k*VW +: VW], unsigned |
| i_out | input | IW | Phase output current, two's complement |
| duty_base | input | NCAP*DW | Modulator duties, duty k in bits [k*DW +: DW] |
| kp | input | GW | Proportional gain, unsigned |
| ki | input | GW | Integral gain, unsigned |
| adj_max | input | DW | Limit on adjustment and integrator magnitude |
| duty_out | output | NCAP*DW | Corrected, saturated duties |
| out_valid | output | 1 | High the cycle after a strobe |

## Verification
The assertions assume the following about the inputs:
- `adj_max` never exceeds 2^FRAC.
- The base duties lie within 0..2^FRAC.
- The strobe is a clean synchronous level.

The bench drives only such values. It changes inputs on the falling edge and holds the strobe for exactly one rising edge. The net-zero assertion compares pre-saturation sums, so it holds even when the stimulus pushes duties into saturation on purpose.

// File: rtl/cbal_pkg.sv
package cbal_pkg;
  localparam int WIDE = 48;
  typedef logic signed [WIDE-1:0] wide_t;

  // symmetric clamp to [-lim, +lim]
  function automatic wide_t clamp_sym(wide_t x, wide_t lim);
    if (x > lim) return lim;
    if (x < -lim) return -lim;
    return x;
  endfunction

  // gain times error, scaled down by an arithmetic shift (floor)
  function automatic wide_t gain_term(wide_t g, wide_t e, int sh);
    wide_t prod;
    prod = g * e;
    return prod >>> sh;
  endfunction

  // clamp to [0, one]
  function automatic wide_t clamp_unit(wide_t x, wide_t one);
    if (x < 0) return '0;
    if (x > one) return one;
    return x;
  endfunction
endpackage

// File: rtl/cbal_pi.sv
module cbal_pi
  import cbal_pkg::*;
#(
  parameter int VW = 12,
  parameter int GW = 8,
  parameter int DW = 16,
  parameter int SH = 4,
  parameter int AW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic [VW-1:0]        v_lo,
  input  logic [VW-1:0]        v_hi,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [DW-1:0]        lim,
  output logic signed [AW-1:0] u
);
  logic signed [AW-1:0] integ_q;
  wide_t err, lim_w, p_term, i_next, u_w;

  always_comb begin
    err    = wide_t'(v_hi) - wide_t'(v_lo);
    lim_w  = wide_t'(lim);
    p_term = gain_term(wide_t'(kp), err, SH);
    i_next = clamp_sym(wide_t'(integ_q) + gain_term(wide_t'(ki), err, SH), lim_w);
    u_w    = clamp_sym(p_term + i_next, lim_w);
    u      = AW'(u_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   integ_q <= '0;
    else if (stb) integ_q <= AW'(i_next);
  end
endmodule

// File: rtl/cbal_combine.sv
module cbal_combine
  import cbal_pkg::*;
#(
  parameter int NCAP = 4,
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = DW + 2,
  parameter int RW   = AW + 2
) (
  input  logic [NCAP*DW-1:0]     base,
  input  logic [(NCAP-1)*AW-1:0] adj,
  output logic [NCAP*RW-1:0]     raw,
  output logic [NCAP*DW-1:0]     duty
);
  localparam int NPAIR = NCAP - 1;
  localparam wide_t ONE = wide_t'(1) <<< FRAC;

  for (genvar k = 0; k < NCAP; k++) begin : g_duty
    logic signed [RW-1:0] b_s, up_s, dn_s, sum_s;
    assign b_s = $signed({{(RW-DW){1'b0}}, base[k*DW +: DW]});
    if (k > 0) begin : g_up
      assign up_s = RW'($signed(adj[(k-1)*AW +: AW]));
    end else begin : g_noup
      assign up_s = '0;
    end
    if (k < NPAIR) begin : g_dn
      assign dn_s = RW'($signed(adj[k*AW +: AW]));
    end else begin : g_nodn
      assign dn_s = '0;
    end
    assign sum_s = b_s + up_s - dn_s;
    assign raw[k*RW +: RW] = sum_s;
    assign duty[k*DW +: DW] = DW'(clamp_unit(wide_t'(sum_s), ONE));
  end
endmodule

// File: rtl/cap_balance_adj.sv
module cap_balance_adj #(
  parameter int NCAP = 4,
  parameter int VW   = 12,
  parameter int IW   = 12,
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int GW   = 8,
  parameter int SH   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_stb,
  input  logic [NCAP*VW-1:0] vcap,
  input  logic [IW-1:0]      i_out,
  input  logic [NCAP*DW-1:0] duty_base,
  input  logic [GW-1:0]      kp,
  input  logic [GW-1:0]      ki,
  input  logic [DW-1:0]      adj_max,
  output logic [NCAP*DW-1:0] duty_out,
  output logic               out_valid
);
  localparam int NPAIR = NCAP - 1;
  localparam int AW    = DW + 2;
  localparam int RW    = AW + 2;

  logic                   cur_neg;
  logic [NPAIR*AW-1:0]    pair_adj;
  logic [NCAP*RW-1:0]     raw_duty;
  logic [NCAP*DW-1:0]     duty_c;

  // zero current counts as positive
  assign cur_neg = i_out[IW-1];

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic signed [AW-1:0] u;
    cbal_pi #(.VW(VW), .GW(GW), .DW(DW), .SH(SH), .AW(AW)) u_pi (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (sample_stb),
      .v_lo (vcap[k*VW +: VW]),
      .v_hi (vcap[(k+1)*VW +: VW]),
      .kp   (kp),
      .ki   (ki),
      .lim  (adj_max),
      .u    (u)
    );
    assign pair_adj[k*AW +: AW] = cur_neg ? -u : u;
  end

  cbal_combine #(.NCAP(NCAP), .DW(DW), .FRAC(FRAC), .AW(AW), .RW(RW)) u_comb (
    .base(duty_base),
    .adj (pair_adj),
    .raw (raw_duty),
    .duty(duty_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= sample_stb;
      if (sample_stb) duty_out <= duty_c;
    end
  end
endmodule

// File: rtl/cbal_chk.sv
module cbal_chk #(
  parameter int NCAP = 4,
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = DW + 2,
  parameter int RW   = AW + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sample_stb,
  input logic                     out_valid,
  input logic [NCAP*DW-1:0]       duty_out,
  input logic [NCAP*DW-1:0]       duty_base,
  input logic [DW-1:0]            adj_max,
  input logic [(NCAP-1)*AW-1:0]   pair_adj,
  input logic [NCAP*RW-1:0]       raw_duty
);
  function automatic longint sum_raw(logic [NCAP*RW-1:0] r);
    longint s = 0;
    for (int k = 0; k < NCAP; k++) s += longint'($signed(r[k*RW +: RW]));
    return s;
  endfunction

  function automatic longint sum_base(logic [NCAP*DW-1:0] b);
    longint s = 0;
    for (int k = 0; k < NCAP; k++) s += longint'(b[k*DW +: DW]);
    return s;
  endfunction

  // R2
  stb_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> out_valid);
  // R2
  valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !out_valid);
  // R2
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(duty_out));
  // R6
  net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_raw(raw_duty) == sum_base(duty_base));

  for (genvar k = 0; k < NCAP - 1; k++) begin : g_adj
    // R9
    adj_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'($signed(pair_adj[k*AW +: AW])) <= longint'(adj_max)) &&
      (longint'($signed(pair_adj[k*AW +: AW])) >= -longint'(adj_max)));
  end

  for (genvar k = 0; k < NCAP; k++) begin : g_rng
    // R10
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (longint'(duty_out[k*DW +: DW]) <= (longint'(1) <<< FRAC)));
  end
endmodule

bind cap_balance_adj cbal_chk #(.NCAP(NCAP), .DW(DW), .FRAC(FRAC), .AW(AW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_stb(sample_stb),
  .out_valid (out_valid),
  .duty_out  (duty_out),
  .duty_base (duty_base),
  .adj_max   (adj_max),
  .pair_adj  (pair_adj),
  .raw_duty  (raw_duty)
);

// File: tb/sim_cap_balance_adj.sv
module sim_cap_balance_adj;
  localparam int CLK_PERIOD = 10;
  localparam int NCAP = 4, VW = 12, IW = 12, DW = 16, FRAC = 14, GW = 8, SH = 4;
  localparam longint ONE = longint'(1) << FRAC;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_stb = 1'b0;
  logic [NCAP*VW-1:0] vcap = '0;
  logic [IW-1:0]      i_out = '0;
  logic [NCAP*DW-1:0] duty_base = '0;
  logic [GW-1:0]      kp = '0, ki = '0;
  logic [DW-1:0]      adj_max = '0;
  logic [NCAP*DW-1:0] duty_out;
  logic               out_valid;

  int vectors = 0;
  int misses = 0;
  longint integ[3];
  longint expd[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_balance_adj #(.NCAP(NCAP), .VW(VW), .IW(IW), .DW(DW), .FRAC(FRAC), .GW(GW), .SH(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .vcap(vcap), .i_out(i_out),
    .duty_base(duty_base), .kp(kp), .ki(ki), .adj_max(adj_max),
    .duty_out(duty_out), .out_valid(out_valid));

  task automatic check(string req, longint got, longint exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint fl_div(longint x);
    longint d = longint'(1) << SH;
    if (x >= 0) return x / d;
    return -((-x + d - 1) / d);
  endfunction

  function automatic longint lim_to(longint x, longint m);
    return (x > m) ? m : ((x < -m) ? -m : x);
  endfunction

  function automatic longint duty_of(int k);
    return longint'(duty_out[k*DW +: DW]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) integ[k] = 0;
  endtask

  // one strobe; model runs its own way, checks all four duties
  task automatic sample(input int v[4], input int cur, input int b[4],
                        input int p, input int i, input int lim, input string req);
    longint a[3];
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      vcap[k*VW +: VW] = VW'(v[k]);
      duty_base[k*DW +: DW] = DW'(b[k]);
    end
    i_out = IW'(cur);
    kp = GW'(p); ki = GW'(i); adj_max = DW'(lim);
    sample_stb = 1'b1;
    for (int k = 0; k < 3; k++) begin
      longint e = longint'(v[k+1]) - longint'(v[k]);
      integ[k] = lim_to(integ[k] + fl_div(longint'(i) * e), lim);
      a[k] = lim_to(fl_div(longint'(p) * e) + integ[k], lim);
      if (cur < 0) a[k] = -a[k];
    end
    for (int k = 0; k < 4; k++) begin
      longint s = b[k];
      if (k > 0) s += a[k-1];
      if (k < 3) s -= a[k];
      expd[k] = (s < 0) ? 0 : ((s > ONE) ? ONE : s);
    end
    @(negedge clk);
    sample_stb = 1'b0;
    check({req, " valid"}, longint'(out_valid), 1);
    for (int k = 0; k < 4; k++) check(req, duty_of(k), expd[k]);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 duty", longint'(duty_out), 0);
    check("R1 valid", longint'(out_valid), 0);
    // R1: integrators zero -> first sample with kp=0 yields pure ki step
    sample('{1000, 1100, 1100, 1100}, 5, '{8000, 8000, 8000, 8000}, 0, 16, 5000, "R1 integ");
  endtask

  task automatic t_balanced();
    do_reset();
    sample('{2000, 2000, 2000, 2000}, 300, '{1000, 6000, 9000, 16000}, 40, 20, 2000, "R6 balanced");
    check("R6 sum", duty_of(0) + duty_of(1) + duty_of(2) + duty_of(3), 32000);
  endtask

  task automatic t_prop_pos();
    do_reset();
    // e0 = +160, kp=16 -> a = 160
    sample('{1000, 1160, 1160, 1160}, 100, '{8000, 8000, 8000, 8000}, 16, 0, 4000, "R7 prop");
    check("R3 lower cut", duty_of(0), 8000 - 160);
    check("R3 upper raised", duty_of(1), 8000 + 160);
    check("R6 sum", duty_of(0) + duty_of(1) + duty_of(2) + duty_of(3), 32000);
  endtask

  task automatic t_zero_cur();
    do_reset();
    sample('{1000, 1160, 1160, 1160}, 0, '{8000, 8000, 8000, 8000}, 16, 0, 4000, "R4 zero");
    check("R4 zero as positive", duty_of(1), 8160);
  endtask

  task automatic t_neg_cur();
    do_reset();
    sample('{1000, 1160, 1160, 1160}, -50, '{8000, 8000, 8000, 8000}, 16, 0, 4000, "R5 neg");
    check("R5 reversed", duty_of(0), 8160);
    check("R5 reversed", duty_of(1), 7840);
    // negative error with floor: e=-3, kp=1 -> floor(-3/16) = -1
    sample('{1003, 1000, 1000, 1000}, 20, '{8000, 8000, 8000, 8000}, 1, 0, 4000, "R7 floor");
  endtask

  task automatic t_integ();
    do_reset();
    // ki*e/16 = 100 per strobe, limit 1000
    for (int n = 1; n <= 13; n++) begin
      sample('{1000, 1000, 1100, 1100}, 10, '{8000, 8000, 8000, 8000}, 0, 16, 1000, "R8 integ");
      check("R9 limited", duty_of(2) - 8000, (n * 100 > 1000) ? 1000 : n * 100);
    end
    // reverse error: anti-windup means it unwinds at once
    sample('{1000, 1000, 900, 900}, 10, '{8000, 8000, 8000, 8000}, 0, 16, 1000, "R8 unwind");
    check("R8 unwind", duty_of(2), 8900);
  endtask

  task automatic t_nostb();
    longint held;
    do_reset();
    sample('{1000, 1000, 1100, 1100}, 10, '{8000, 8000, 8000, 8000}, 0, 16, 1000, "R12 first");
    held = longint'(duty_out);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      vcap = {12'd50, 12'd4000, 12'd10, 12'd3000};
      duty_base = {16'd1, 16'd2, 16'd3, 16'd4};
      check("R2 no valid", longint'(out_valid), 0);
      check("R2 hold", longint'(duty_out), held);
    end
    // integrator advanced exactly once more: 200
    sample('{1000, 1000, 1100, 1100}, 10, '{8000, 8000, 8000, 8000}, 0, 16, 1000, "R12 second");
    check("R12 single step", duty_of(2), 8200);
  endtask

  task automatic t_sat();
    do_reset();
    sample('{0, 4000, 4000, 4000}, 5, '{100, 16300, 8000, 8000}, 255, 0, 16384, "R10 sat");
    check("R10 low clamp", duty_of(0), 0);
    check("R10 high clamp", duty_of(1), ONE);
  endtask

  task automatic t_three();
    do_reset();
    sample('{1000, 1200, 1100, 1300}, 7, '{4000, 8000, 9000, 12000}, 32, 8, 3000, "R11 three pairs");
    sample('{1000, 1200, 1100, 1300}, -7, '{4000, 8000, 9000, 12000}, 32, 8, 3000, "R11 three pairs neg");
  endtask

  initial begin
    t_reset();
    t_balanced();
    t_prop_pos();
    t_zero_cur();
    t_neg_cur();
    t_integ();
    t_nostb();
    t_sat();
    t_three();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule